// File: doc/BRIEF.md
# Duty-Cycle Amplifier Enable Sequencer

This controller runs from the crystal oscillator's own output clock and brings a low-power oscillator from power-up to steady duty-cycled operation. After reset it keeps the amplifier on for trimming. It then steps through a growth measurement, with the amplifier on, and a decay measurement, with the amplifier off. Each step ends when the helper block for that step reports that it is done. Only one helper enable is active at a time, so every helper is powered down once its result has been stored.

In the final phase the block generates a slow periodic clock that gates the amplifier. The clock is high for the stored growth count and low for the stored decay count, both counted in oscillator cycles, and it repeats until the next reset. A count of zero is stretched to one cycle. A new count takes effect only when the clock next enters the half it governs. With a 32.768 kHz oscillator and counts in the expected range, the gating clock runs at a few hertz to a few tens of hertz.

There are no streaming interfaces. All pins are plain control and status levels, and every input is sampled on the rising oscillator edge.

Top module: `dcyc_amp_seq`

## Requirements
- R1: Synchronous reset (rst=1 at a rising edge) leaves cal_en=1, amp_en=1, and grow_en, decay_en, run_en and dc_clk all at 0.
- R2: Phases advance only in this order: calibrate (cal_en) to growth (grow_en) when cal_done=1, growth to decay (decay_en) when grow_done=1, decay to run (run_en) when decay_done=1. Each advance happens one edge after the flag is seen, and exactly one of the four enables is 1 at any time.
- R3: A done flag that belongs to a phase other than the current one has no effect; the phase enables stay unchanged.
- R4: amp_en is 1 in the calibrate and growth phases and 0 in the decay phase. In the run phase it equals dc_clk.
- R5: In the first run cycle dc_clk is 1, and it stays 1 for exactly G cycles, where G is the growth count loaded on entry.
- R6: After each high half, dc_clk is 0 for exactly D cycles, where D is decay_count sampled at the high-to-low edge. It then goes high again for grow_count sampled at the low-to-high edge, and this repeats, giving a period of G+D cycles.
- R7: A count value of 0 gives a half of exactly one cycle.
- R8: A change of grow_count or decay_count in the middle of a half never shortens or lengthens that half; the change is used at the next boundary where that count is loaded.
- R9: dc_clk is 0 in every phase except run. Once the run phase is reached, no done flag leaves it.
- R10: Reset asserted during the run phase returns the block to the calibrate state of R1 at the next edge.
- R11: The full-scale count 2^CNT_W-1 gives exactly that many cycles, without wrap-around.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator output clock |
| rst | input | 1 | Synchronous reset, active high |
| cal_done | input | 1 | Amplifier trim finished |
| grow_done | input | 1 | Growth measurement stored |
| decay_done | input | 1 | Decay measurement stored |
| grow_count | input | CNT_W | High-half length in oscillator cycles |
| decay_count | input | CNT_W | Low-half length in oscillator cycles |
| cal_en | output | 1 | Enable for the trim helper |
| grow_en | output | 1 | Enable for the growth measurement helper |
| decay_en | output | 1 | Enable for the decay measurement helper |
| run_en | output | 1 | Duty-cycled operation active |
| amp_en | output | 1 | Amplifier enable |
| dc_clk | output | 1 | Duty-cycle gating clock |

## Verification
The bench builds the block with CNT_W=6, so the full-scale count of 63 cycles is short enough to run through completely, and the terminal compare and the no-wrap behaviour are seen at their real width. Small counts of 0, 1, 3 and 4 exercise the one-cycle stretch, back-to-back boundaries, and count changes made in the middle of a half. Several runs are separated by resets, so the phase walk is repeated from scratch each time.

// File: rtl/dcyc_pkg.sv
package dcyc_pkg;
  typedef enum logic [1:0] {
    PH_CAL   = 2'd0,
    PH_GROW  = 2'd1,
    PH_DECAY = 2'd2,
    PH_RUN   = 2'd3
  } phase_e;
endpackage

// File: rtl/dcyc_phase_fsm.sv
module dcyc_phase_fsm
  import dcyc_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   cal_done,
  input  logic   grow_done,
  input  logic   decay_done,
  output phase_e phase,
  output logic   cal_en,
  output logic   grow_en,
  output logic   decay_en,
  output logic   run_en
);
  phase_e phase_q, phase_d;

  always_comb begin
    phase_d = phase_q;
    unique case (phase_q)
      PH_CAL:   if (cal_done)   phase_d = PH_GROW;
      PH_GROW:  if (grow_done)  phase_d = PH_DECAY;
      PH_DECAY: if (decay_done) phase_d = PH_RUN;
      default:                  phase_d = PH_RUN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) phase_q <= PH_CAL;
    else     phase_q <= phase_d;
  end

  assign phase    = phase_q;
  assign cal_en   = (phase_q == PH_CAL);
  assign grow_en  = (phase_q == PH_GROW);
  assign decay_en = (phase_q == PH_DECAY);
  assign run_en   = (phase_q == PH_RUN);

  // R2: a done flag moves the sequence exactly one step
  p_cal_step_r2: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_CAL && cal_done) |=> phase_q == PH_GROW);
  p_grow_step_r2: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_GROW && grow_done) |=> phase_q == PH_DECAY);
  p_decay_step_r2: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_DECAY && decay_done) |=> phase_q == PH_RUN);
  // R3: flags of other phases leave the calibrate phase in place
  p_cal_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_CAL && !cal_done) |=> phase_q == PH_CAL);
  // R9: the run phase is terminal
  p_run_sticky_r9: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_RUN) |=> phase_q == PH_RUN);
endmodule

// File: rtl/dcyc_period_gen.sv
module dcyc_period_gen #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run_en,
  input  logic [CNT_W-1:0] grow_count,
  input  logic [CNT_W-1:0] decay_count,
  output logic             dc_clk
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic             hi_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] len_q;
  logic [CNT_W-1:0] grow_eff, decay_eff;
  logic             at_end;

  // zero lengths are stretched to one cycle so the loop never stalls
  assign grow_eff  = (grow_count  == '0) ? ONE : grow_count;
  assign decay_eff = (decay_count == '0) ? ONE : decay_count;
  assign at_end    = (cnt_q == len_q);

  always_ff @(posedge clk) begin
    if (rst || !run_en) begin
      hi_q  <= 1'b1;
      cnt_q <= ONE;
      len_q <= grow_eff;
    end else if (at_end) begin
      hi_q  <= !hi_q;
      cnt_q <= ONE;
      len_q <= hi_q ? decay_eff : grow_eff;
    end else begin
      cnt_q <= cnt_q + ONE;
    end
  end

  assign dc_clk = run_en & hi_q;

  // R7: a half is never zero cycles long
  p_len_nonzero_r7: assert property (@(posedge clk) disable iff (rst)
    run_en |-> len_q != '0);
  // R5: the position counter stays inside the current half (R11: no wrap)
  p_cnt_in_range_r5: assert property (@(posedge clk) disable iff (rst)
    run_en |-> (cnt_q >= ONE && cnt_q <= len_q));
  // R8: length only reloads at a boundary
  p_no_midload_r8: assert property (@(posedge clk) disable iff (rst)
    (run_en && $past(run_en) && cnt_q != ONE) |-> $stable(len_q));
  // R6: a finished half always flips the level
  p_flip_r6: assert property (@(posedge clk) disable iff (rst)
    (run_en && $past(run_en) && $past(at_end)) |-> hi_q != $past(hi_q));
endmodule

// File: rtl/dcyc_amp_seq.sv
module dcyc_amp_seq
  import dcyc_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cal_done,
  input  logic             grow_done,
  input  logic             decay_done,
  input  logic [CNT_W-1:0] grow_count,
  input  logic [CNT_W-1:0] decay_count,
  output logic             cal_en,
  output logic             grow_en,
  output logic             decay_en,
  output logic             run_en,
  output logic             amp_en,
  output logic             dc_clk
);
  phase_e phase;

  dcyc_phase_fsm u_fsm (
    .clk        (clk),
    .rst        (rst),
    .cal_done   (cal_done),
    .grow_done  (grow_done),
    .decay_done (decay_done),
    .phase      (phase),
    .cal_en     (cal_en),
    .grow_en    (grow_en),
    .decay_en   (decay_en),
    .run_en     (run_en)
  );

  dcyc_period_gen #(.CNT_W(CNT_W)) u_gen (
    .clk         (clk),
    .rst         (rst),
    .run_en      (run_en),
    .grow_count  (grow_count),
    .decay_count (decay_count),
    .dc_clk      (dc_clk)
  );

  always_comb begin
    unique case (phase)
      PH_CAL:   amp_en = 1'b1;
      PH_GROW:  amp_en = 1'b1;
      PH_DECAY: amp_en = 1'b0;
      default:  amp_en = dc_clk;
    endcase
  end

  // R2: exactly one phase enable
  p_onehot_r2: assert property (@(posedge clk) disable iff (rst)
    $countones({cal_en, grow_en, decay_en, run_en}) == 1);
  // R4: amplifier idle while decay is measured
  p_decay_off_r4: assert property (@(posedge clk) disable iff (rst)
    decay_en |-> !amp_en);
  // R9: no gating clock outside the run phase
  p_dc_idle_r9: assert property (@(posedge clk) disable iff (rst)
    !run_en |-> !dc_clk);
  // R10: reset lands in calibrate with the amplifier on
  p_reset_cal_r10: assert property (@(posedge clk)
    rst |=> (cal_en && amp_en && !dc_clk));
endmodule

// File: tb/test_dcyc_amp_seq.sv
module test_dcyc_amp_seq;
  localparam int CNT_W = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cal_done = 1'b0, grow_done = 1'b0, decay_done = 1'b0;
  logic [CNT_W-1:0] grow_count = '0, decay_count = '0;
  logic cal_en, grow_en, decay_en, run_en, amp_en, dc_clk;

  int n_cmp = 0;
  int n_bad = 0;
  bit exp_q[$];

  always #5 clk = ~clk;

  dcyc_amp_seq #(.CNT_W(CNT_W)) i_dcyc_amp_seq (
    .clk(clk), .rst(rst), .cal_done(cal_done), .grow_done(grow_done),
    .decay_done(decay_done), .grow_count(grow_count), .decay_count(decay_count),
    .cal_en(cal_en), .grow_en(grow_en), .decay_en(decay_en), .run_en(run_en),
    .amp_en(amp_en), .dc_clk(dc_clk)
  );

  task automatic chk(string req, logic act, logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  // driver side: expected gating pattern for n periods
  task automatic push_halves(int hi, int lo, int n);
    for (int p = 0; p < n; p++) begin
      for (int i = 0; i < hi; i++) exp_q.push_back(1'b1);
      for (int i = 0; i < lo; i++) exp_q.push_back(1'b0);
    end
  endtask

  // monitor: one expected level per run cycle
  always @(negedge clk) begin
    if (!rst && run_en === 1'b1 && exp_q.size() > 0) begin
      bit e;
      e = exp_q.pop_front();
      chk("R5/R6 dc_clk", dc_clk, e);
      chk("R4 amp_en in run", amp_en, e);
    end
  end

  task automatic check_reset_state();
    chk("R1 cal_en", cal_en, 1'b1);
    chk("R1 amp_en", amp_en, 1'b1);
    chk("R1 grow_en", grow_en, 1'b0);
    chk("R1 decay_en", decay_en, 1'b0);
    chk("R1 run_en", run_en, 1'b0);
    chk("R1 dc_clk", dc_clk, 1'b0);
  endtask

  task automatic go_to_run(int g, int d);
    grow_count = CNT_W'(g);
    decay_count = CNT_W'(d);
    grow_done = 1; decay_done = 1;
    @(negedge clk); grow_done = 0; decay_done = 0;
    chk("R3 stray flags in calibrate", cal_en, 1'b1);
    cal_done = 1;
    @(negedge clk); cal_done = 0;
    chk("R2 growth phase", grow_en, 1'b1);
    chk("R4 amp on in growth", amp_en, 1'b1);
    cal_done = 1; decay_done = 1;
    @(negedge clk); cal_done = 0; decay_done = 0;
    chk("R3 stray flags in growth", grow_en, 1'b1);
    grow_done = 1;
    @(negedge clk); grow_done = 0;
    chk("R2 decay phase", decay_en, 1'b1);
    chk("R4 amp off in decay", amp_en, 1'b0);
    chk("R9 dc_clk idle", dc_clk, 1'b0);
    decay_done = 1;
    @(negedge clk); decay_done = 0;
    chk("R2 run phase", run_en, 1'b1);
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(negedge clk);
  endtask

  task automatic reset_pulse(string req);
    rst = 1;
    @(negedge clk);
    rst = 0;
    chk({req, " cal_en"}, cal_en, 1'b1);
    chk({req, " amp_en"}, amp_en, 1'b1);
    chk({req, " run_en"}, run_en, 1'b0);
    chk({req, " dc_clk"}, dc_clk, 1'b0);
  endtask

  initial begin
    #1_000_000;
    n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    check_reset_state();

    // R8: G shrinks and D grows in mid-high; first high keeps 3, then 1 high / 4 low
    push_halves(3, 0, 1);
    push_halves(0, 4, 1);
    push_halves(1, 4, 3);
    go_to_run(3, 2);
    @(negedge clk);
    grow_count = CNT_W'(1);
    decay_count = CNT_W'(4);
    drain();
    cal_done = 1; grow_done = 1; decay_done = 1;
    @(negedge clk); cal_done = 0; grow_done = 0; decay_done = 0;
    @(negedge clk);
    chk("R9 run is terminal", run_en, 1'b1);
    reset_pulse("R10");

    // R7: zero counts give a one-cycle toggle
    push_halves(1, 1, 5);
    go_to_run(0, 0);
    drain();
    reset_pulse("R10 second");

    // R11: full-scale high half, then plain 4/2
    push_halves(63, 2, 1);
    push_halves(4, 2, 2);
    go_to_run(63, 2);
    @(negedge clk);
    grow_count = CNT_W'(4);
    drain();

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule